// File: doc/BRIEF.md
# Delayed Per-Word Disambiguation Buffer

This block keeps a small table of unresolved cross-thread read hazards for a line-granular speculative memory system. When a speculative consumer thread reads a line that an earlier thread may also write, the caller allocates an entry holding the line tag, the consumer thread number, the handling mode and a predicted line value. From then on, every commit of an earlier thread reports which words of a line it wrote, and the matching entries gather those words into a per-word hazard mask. Ordinary loads and stores therefore never need to carry word addresses.

When the consumer stops being speculative, the caller hands over the consumer's per-word load bits. The block walks the whole table at a fixed cost per entry and reports whether the consumer must be squashed. It frees every entry the consumer owned. In disambiguate mode any predecessor write to a loaded word is a hazard. In value-predict mode a write is a hazard only if the written word differs from the predicted word. When no entry is free, an allocation request returns a fallback so that the caller can squash conservatively.

Top module: `wdp_buffer`

## Requirements
- R1: After reset `alloc_ok`, `alloc_fallback`, `resolve_busy`, `resolve_done`, `resolve_squash` and `resolve_found` are all 0. An allocation request accepted at a clock edge while a free entry exists gives `alloc_ok`=1 and `alloc_fallback`=0 during the following cycle.
- R2: An allocation request made while all NUM_ENTRIES entries are valid gives `alloc_fallback`=1 and `alloc_ok`=0 during the following cycle, and it changes no stored entry.
- R3: In disambiguate mode (`alloc_mode`=0), a commit with a matching tag sets the hazard bit of every word flagged in `commit_wmask` (bit w = word w, data bits [32w+31:32w]). Resolution squashes when any word set in `resolve_load` has its hazard bit set.
- R4: In disambiguate mode, predecessor writes that touch only words the consumer did not load give `resolve_squash`=0.
- R5: In value-predict mode (`alloc_mode`=1), a written word sets its hazard bit only if its committed data differs from the predicted word in `alloc_pred`. A write of the same value gives no squash.
- R6: A commit changes an entry only when the entry is valid, the tags are equal, and the entry's consumer thread number is strictly greater (unsigned) than `commit_tid`. Other commits have no effect on the result.
- R7: A resolve request is accepted when `resolve_busy`=0. `resolve_done` pulses for one cycle exactly SCAN_CYCLES*NUM_ENTRIES clock edges after the accepting edge, and `resolve_busy` is 1 for the whole scan.
- R8: Resolution frees every entry of the consumer thread, so their slots can be allocated again. `resolve_found` is 1 with `resolve_done` only if at least one entry of that thread existed. With no such entry, `resolve_squash`=0.
- R9: If a thread owns several entries, `resolve_squash` is the OR of the per-entry outcomes.
- R10: A resolve request made while `resolve_busy`=1 is ignored: it starts no scan and frees no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a pending entry this cycle |
| alloc_tag | input | TAG_W | Line tag of the new entry |
| alloc_tid | input | TID_W | Consumer thread number |
| alloc_mode | input | 1 | 0 disambiguate, 1 value-predict |
| alloc_pred | input | WORDS*WORD_W | Predicted line value, word w at bits [32w+31:32w] |
| alloc_ok | output | 1 | Previous request stored an entry |
| alloc_fallback | output | 1 | Previous request found the table full |
| commit_valid | input | 1 | A thread commits writes to a line |
| commit_tag | input | TAG_W | Line tag of the commit |
| commit_tid | input | TID_W | Committing thread number |
| commit_wmask | input | WORDS | Words written by the commit |
| commit_data | input | WORDS*WORD_W | Committed line value |
| resolve_valid | input | 1 | Consumer became non-speculative |
| resolve_tid | input | TID_W | Thread to resolve |
| resolve_load | input | WORDS | Words the consumer loaded |
| resolve_busy | output | 1 | Scan in progress |
| resolve_done | output | 1 | One-cycle result strobe |
| resolve_squash | output | 1 | Consumer must be squashed (valid with done) |
| resolve_found | output | 1 | Thread had at least one entry (valid with done) |

## Verification
A stale hazard mask, a wrong tag or thread comparison, or a mishandled value comparison appears only at the `resolve_done` strobe of that consumer, as a wrong `resolve_squash`. That strobe comes one full scan (SCAN_CYCLES*NUM_ENTRIES cycles) after the request. An entry that is not freed, or that is freed twice, shows up later: either as a false `resolve_found` on a second resolve of the same thread, or as `alloc_fallback` arriving one allocation early or late when the table is filled. A broken scan counter shifts the done strobe away from its exact cycle.

// File: rtl/wdp_pkg.sv
`timescale 1ns/1ps
package wdp_pkg;
  typedef enum logic {
    MODE_DISAMB  = 1'b0,
    MODE_VALPRED = 1'b1
  } wdp_mode_e;
endpackage

// File: rtl/wdp_free_pick.sv
`timescale 1ns/1ps
// Lowest-index free slot finder.
module wdp_free_pick #(
  parameter int N     = 128,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     used,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wdp_hazard_calc.sv
`timescale 1ns/1ps
// Per-entry hazard bits produced by one commit.
module wdp_hazard_calc
  import wdp_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int TAG_W  = 26,
  parameter int TID_W  = 6,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [TID_W-1:0]  ent_tid,
  input  wdp_mode_e         ent_mode,
  input  logic [LINE_W-1:0] ent_pred,
  input  logic              cm_valid,
  input  logic [TAG_W-1:0]  cm_tag,
  input  logic [TID_W-1:0]  cm_tid,
  input  logic [WORDS-1:0]  cm_wmask,
  input  logic [LINE_W-1:0] cm_data,
  output logic [WORDS-1:0]  set_mask
);
  logic applies;
  assign applies = ent_valid && cm_valid && (ent_tag == cm_tag) && (ent_tid > cm_tid);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic differs;
    assign differs = cm_data[w*WORD_W +: WORD_W] != ent_pred[w*WORD_W +: WORD_W];
    assign set_mask[w] = applies && cm_wmask[w] &&
                         ((ent_mode == MODE_DISAMB) || differs);
  end
endmodule

// File: rtl/wdp_scan_ctrl.sv
`timescale 1ns/1ps
// Sequential table walk: SCAN_CYC cycles per entry.
module wdp_scan_ctrl #(
  parameter int N        = 128,
  parameter int SCAN_CYC = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int SUB_W = (SCAN_CYC > 1) ? $clog2(SCAN_CYC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             eval,
  output logic             last,
  output logic [IDX_W-1:0] idx
);
  logic             busy_d;
  logic [IDX_W-1:0] idx_d;
  logic [SUB_W-1:0] sub_q, sub_d;

  assign eval = busy && (sub_q == SUB_W'(SCAN_CYC - 1));
  assign last = eval && (idx == IDX_W'(N - 1));

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    sub_d  = sub_q;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        sub_d  = '0;
      end
    end else if (eval) begin
      sub_d = '0;
      if (last) busy_d = 1'b0;
      else      idx_d  = idx + 1'b1;
    end else begin
      sub_d = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      sub_q <= '0;
    end else begin
      busy  <= busy_d;
      idx   <= idx_d;
      sub_q <= sub_d;
    end
  end

  p_scan_starts_on_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_sub_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sub_q < SUB_W'(SCAN_CYC)));
endmodule

// File: rtl/wdp_buffer.sv
`timescale 1ns/1ps
module wdp_buffer
  import wdp_pkg::*;
#(
  parameter int NUM_ENTRIES = 128,
  parameter int SCAN_CYCLES = 3,
  parameter int WORDS       = 4,
  parameter int WORD_W      = 32,
  parameter int TAG_W       = 26,
  parameter int TID_W       = 6,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [TID_W-1:0]  alloc_tid,
  input  logic              alloc_mode,
  input  logic [LINE_W-1:0] alloc_pred,
  output logic              alloc_ok,
  output logic              alloc_fallback,
  input  logic              commit_valid,
  input  logic [TAG_W-1:0]  commit_tag,
  input  logic [TID_W-1:0]  commit_tid,
  input  logic [WORDS-1:0]  commit_wmask,
  input  logic [LINE_W-1:0] commit_data,
  input  logic              resolve_valid,
  input  logic [TID_W-1:0]  resolve_tid,
  input  logic [WORDS-1:0]  resolve_load,
  output logic              resolve_busy,
  output logic              resolve_done,
  output logic              resolve_squash,
  output logic              resolve_found
);
  // Entry storage
  logic [NUM_ENTRIES-1:0] ent_valid_q;
  logic [TAG_W-1:0]       ent_tag_q  [NUM_ENTRIES];
  logic [TID_W-1:0]       ent_tid_q  [NUM_ENTRIES];
  wdp_mode_e              ent_mode_q [NUM_ENTRIES];
  logic [LINE_W-1:0]      ent_pred_q [NUM_ENTRIES];
  logic [WORDS-1:0]       ent_mask_q [NUM_ENTRIES];

  // Allocation
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             alloc_fire;
  logic             alloc_ok_d, alloc_fb_d;

  wdp_free_pick #(.N(NUM_ENTRIES)) u_pick (
    .used  (ent_valid_q),
    .found (free_found),
    .idx   (free_idx)
  );

  assign alloc_fire = alloc_valid && free_found;
  assign alloc_ok_d = alloc_fire;
  assign alloc_fb_d = alloc_valid && !free_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_ok       <= 1'b0;
      alloc_fallback <= 1'b0;
    end else begin
      alloc_ok       <= alloc_ok_d;
      alloc_fallback <= alloc_fb_d;
    end
  end

  // Scan
  logic             scan_start, scan_eval, scan_last;
  logic [IDX_W-1:0] scan_idx;
  logic [TID_W-1:0] res_tid_q;
  logic [WORDS-1:0] res_load_q;
  logic             acc_squash_q, acc_found_q;
  logic             acc_squash_d, acc_found_d;
  logic             done_d, squash_d, found_d;
  logic             cur_match, cur_squash;

  assign scan_start = resolve_valid && !resolve_busy;

  wdp_scan_ctrl #(.N(NUM_ENTRIES), .SCAN_CYC(SCAN_CYCLES)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (scan_start),
    .busy  (resolve_busy),
    .eval  (scan_eval),
    .last  (scan_last),
    .idx   (scan_idx)
  );

  assign cur_match  = scan_eval && ent_valid_q[scan_idx] &&
                      (ent_tid_q[scan_idx] == res_tid_q);
  assign cur_squash = cur_match && |(res_load_q & ent_mask_q[scan_idx]);

  always_comb begin
    acc_squash_d = acc_squash_q;
    acc_found_d  = acc_found_q;
    done_d       = 1'b0;
    squash_d     = 1'b0;
    found_d      = 1'b0;
    if (scan_start) begin
      acc_squash_d = 1'b0;
      acc_found_d  = 1'b0;
    end else if (scan_eval) begin
      acc_squash_d = acc_squash_q | cur_squash;
      acc_found_d  = acc_found_q  | cur_match;
      if (scan_last) begin
        done_d   = 1'b1;
        squash_d = acc_squash_d;
        found_d  = acc_found_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_squash_q   <= 1'b0;
      acc_found_q    <= 1'b0;
      resolve_done   <= 1'b0;
      resolve_squash <= 1'b0;
      resolve_found  <= 1'b0;
    end else begin
      acc_squash_q   <= acc_squash_d;
      acc_found_q    <= acc_found_d;
      resolve_done   <= done_d;
      resolve_squash <= squash_d;
      resolve_found  <= found_d;
    end
  end

  always_ff @(posedge clk) begin
    if (scan_start) begin
      res_tid_q  <= resolve_tid;
      res_load_q <= resolve_load;
    end
  end

  // Per-entry update
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic             alloc_hit, free_hit, valid_d;
    logic [WORDS-1:0] set_mask, mask_d;

    wdp_hazard_calc #(
      .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .TID_W(TID_W)
    ) u_haz (
      .ent_valid (ent_valid_q[i]),
      .ent_tag   (ent_tag_q[i]),
      .ent_tid   (ent_tid_q[i]),
      .ent_mode  (ent_mode_q[i]),
      .ent_pred  (ent_pred_q[i]),
      .cm_valid  (commit_valid),
      .cm_tag    (commit_tag),
      .cm_tid    (commit_tid),
      .cm_wmask  (commit_wmask),
      .cm_data   (commit_data),
      .set_mask  (set_mask)
    );

    assign alloc_hit = alloc_fire && (free_idx == IDX_W'(i));
    assign free_hit  = cur_match && (scan_idx == IDX_W'(i));

    always_comb begin
      valid_d = ent_valid_q[i];
      mask_d  = ent_mask_q[i] | set_mask;
      if (alloc_hit) begin
        valid_d = 1'b1;
        mask_d  = '0;
      end else if (free_hit) begin
        valid_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_valid_q[i] <= 1'b0;
      else        ent_valid_q[i] <= valid_d;
    end

    always_ff @(posedge clk) begin
      ent_mask_q[i] <= mask_d;
      if (alloc_hit) begin
        ent_tag_q[i]  <= alloc_tag;
        ent_tid_q[i]  <= alloc_tid;
        ent_mode_q[i] <= wdp_mode_e'(alloc_mode);
        ent_pred_q[i] <= alloc_pred;
      end
    end
  end

  // Assertions
  p_alloc_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_ok && alloc_fallback));
  p_fallback_only_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fallback |-> (&$past(ent_valid_q)));
  p_done_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_done |=> !resolve_done);
  p_done_ends_scan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_done |-> (!resolve_busy && $past(resolve_busy)));
  p_squash_needs_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_squash |-> resolve_found);
  p_tid_held_in_scan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_busy && $past(resolve_busy)) |-> $stable(res_tid_q));
endmodule

// File: tb/tb_wdp_buffer.sv
`timescale 1ns/1ps
module tb_wdp_buffer;
  localparam int NE   = 128;
  localparam int SC   = 3;
  localparam int NW   = 4;
  localparam int WW   = 32;
  localparam int TW   = 26;
  localparam int IW   = 6;
  localparam int LW   = NW * WW;
  localparam int LAT  = SC * NE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [TW-1:0] alloc_tag = '0;
  logic [IW-1:0] alloc_tid = '0;
  logic          alloc_mode = 1'b0;
  logic [LW-1:0] alloc_pred = '0;
  logic          alloc_ok, alloc_fallback;
  logic          commit_valid = 1'b0;
  logic [TW-1:0] commit_tag = '0;
  logic [IW-1:0] commit_tid = '0;
  logic [NW-1:0] commit_wmask = '0;
  logic [LW-1:0] commit_data = '0;
  logic          resolve_valid = 1'b0;
  logic [IW-1:0] resolve_tid = '0;
  logic [NW-1:0] resolve_load = '0;
  logic          resolve_busy, resolve_done, resolve_squash, resolve_found;

  always #4 clk = ~clk;

  wdp_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_tid(alloc_tid),
    .alloc_mode(alloc_mode), .alloc_pred(alloc_pred),
    .alloc_ok(alloc_ok), .alloc_fallback(alloc_fallback),
    .commit_valid(commit_valid), .commit_tag(commit_tag), .commit_tid(commit_tid),
    .commit_wmask(commit_wmask), .commit_data(commit_data),
    .resolve_valid(resolve_valid), .resolve_tid(resolve_tid), .resolve_load(resolve_load),
    .resolve_busy(resolve_busy), .resolve_done(resolve_done),
    .resolve_squash(resolve_squash), .resolve_found(resolve_found)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference table
  bit            m_valid [NE];
  logic [TW-1:0] m_tag   [NE];
  logic [IW-1:0] m_tid   [NE];
  bit            m_mode  [NE];
  logic [LW-1:0] m_pred  [NE];
  logic [NW-1:0] m_mask  [NE];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mkline(input int a, input int b, input int c, input int d);
    logic [LW-1:0] l;
    l[0*WW +: WW] = WW'(a);
    l[1*WW +: WW] = WW'(b);
    l[2*WW +: WW] = WW'(c);
    l[3*WW +: WW] = WW'(d);
    return l;
  endfunction

  function automatic int model_free();
    for (int i = 0; i < NE; i++) if (!m_valid[i]) return i;
    return -1;
  endfunction

  task automatic do_alloc(input int tag, input int tid, input bit mode, input logic [LW-1:0] pred,
                          input string req);
    int slot;
    slot = model_free();
    @(negedge clk);
    alloc_valid = 1'b1; alloc_tag = TW'(tag); alloc_tid = IW'(tid);
    alloc_mode = mode; alloc_pred = pred;
    @(posedge clk); #1;
    alloc_valid = 1'b0;
    @(negedge clk);
    check(req, alloc_ok, (slot >= 0));
    check(req, alloc_fallback, (slot < 0));
    if (slot >= 0) begin
      m_valid[slot] = 1'b1; m_tag[slot] = TW'(tag); m_tid[slot] = IW'(tid);
      m_mode[slot] = mode; m_pred[slot] = pred; m_mask[slot] = '0;
    end
  endtask

  task automatic do_commit(input int tag, input int tid, input logic [NW-1:0] wm,
                           input logic [LW-1:0] data);
    @(negedge clk);
    commit_valid = 1'b1; commit_tag = TW'(tag); commit_tid = IW'(tid);
    commit_wmask = wm; commit_data = data;
    @(posedge clk); #1;
    commit_valid = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (m_valid[i] && m_tag[i] == TW'(tag) && m_tid[i] > IW'(tid)) begin
        for (int w = 0; w < NW; w++) begin
          if (wm[w] && (!m_mode[i] || data[w*WW +: WW] != m_pred[i][w*WW +: WW]))
            m_mask[i][w] = 1'b1;
        end
      end
    end
  endtask

  task automatic do_resolve(input int tid, input logic [NW-1:0] load, input bit inject,
                            input int itid, input string req);
    bit exp_sq, exp_fd, got;
    int cyc;
    exp_sq = 1'b0; exp_fd = 1'b0;
    for (int i = 0; i < NE; i++) begin
      if (m_valid[i] && m_tid[i] == IW'(tid)) begin
        exp_fd = 1'b1;
        if (|(load & m_mask[i])) exp_sq = 1'b1;
        m_valid[i] = 1'b0;
      end
    end
    @(negedge clk);
    resolve_valid = 1'b1; resolve_tid = IW'(tid); resolve_load = load;
    @(posedge clk); #1;
    resolve_valid = 1'b0;
    cyc = 0; got = 1'b0;
    while (!got && cyc < LAT + 20) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      resolve_valid = 1'b0;
      if (cyc == 10) check("R7 busy during scan", resolve_busy, 1);
      if (resolve_done) got = 1'b1;
      else if (inject && cyc == 5) begin
        resolve_valid = 1'b1; resolve_tid = IW'(itid); resolve_load = '1;
      end
    end
    check("R7 done seen", got, 1);
    check("R7 latency", cyc, LAT);
    check({req, " squash"}, resolve_squash, exp_sq);
    check({req, " found"}, resolve_found, exp_fd);
    @(negedge clk);
    check("R7 done one cycle", resolve_done, 0);
  endtask

  task automatic flush(input string req);
    for (int t = 0; t < 8; t++) do_resolve(t, '1, 1'b0, 0, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < NE; i++) m_valid[i] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset alloc_ok", alloc_ok, 0);
    check("R1 reset fallback", alloc_fallback, 0);
    check("R1 reset busy", resolve_busy, 0);
    check("R1 reset done", resolve_done, 0);
    check("R1 reset squash", resolve_squash, 0);
    check("R1 reset found", resolve_found, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: load word 1, predecessor writes word 3 only
    do_alloc(5, 4, 1'b0, '0, "R1 alloc");
    do_commit(5, 2, 4'b1000, '0);
    do_resolve(4, 4'b0010, 1'b0, 0, "R4 other word");

    // R3: predecessor writes the loaded word
    do_alloc(5, 4, 1'b0, '0, "R1 alloc");
    do_commit(5, 2, 4'b1000, '0);
    do_commit(5, 3, 4'b0010, '0);
    do_resolve(4, 4'b0010, 1'b0, 0, "R3 same word");

    // R5: value-predict, same value then different value
    do_alloc(7, 6, 1'b1, mkline(0, 25, 0, 0), "R1 alloc");
    do_commit(7, 1, 4'b0010, mkline(0, 25, 0, 0));
    do_resolve(6, 4'b0010, 1'b0, 0, "R5 equal value");
    do_alloc(7, 6, 1'b1, mkline(0, 25, 0, 0), "R1 alloc");
    do_commit(7, 1, 4'b0010, mkline(0, 26, 0, 0));
    do_resolve(6, 4'b0010, 1'b0, 0, "R5 changed value");

    // R6: later thread, equal thread, other tag
    do_alloc(9, 3, 1'b0, '0, "R1 alloc");
    do_commit(9, 5, 4'b1111, '0);
    do_commit(9, 3, 4'b1111, '0);
    do_commit(8, 1, 4'b1111, '0);
    do_resolve(3, 4'b1111, 1'b0, 0, "R6 ignored commits");

    // R9: several entries of one thread, one hazardous
    do_alloc(1, 5, 1'b0, '0, "R1 alloc");
    do_alloc(2, 5, 1'b0, '0, "R1 alloc");
    do_commit(2, 0, 4'b0100, '0);
    do_resolve(5, 4'b0100, 1'b0, 0, "R9 or of entries");

    // R8: no entry for thread
    do_resolve(2, 4'b1111, 1'b0, 0, "R8 empty thread");

    // R10: request during scan ignored
    do_alloc(3, 1, 1'b0, '0, "R1 alloc");
    do_alloc(4, 2, 1'b0, '0, "R1 alloc");
    do_commit(4, 0, 4'b0001, '0);
    do_resolve(1, 4'b1111, 1'b1, 2, "R10 first scan");
    do_resolve(2, 4'b0001, 1'b0, 0, "R10 entry kept");

    // R2: fill the table, then one more
    for (int i = 0; i < NE; i++) do_alloc(i % 4, i % 8, 1'b0, '0, "R1 fill");
    do_alloc(0, 1, 1'b0, '0, "R2 full");
    do_commit(1, 0, 4'b0010, '0);
    flush("R8 flush full");
    do_alloc(0, 1, 1'b0, '0, "R8 reuse after free");
    do_resolve(1, 4'b1111, 1'b0, 0, "R8 reuse resolve");

    // Random rounds
    for (int r = 0; r < 25; r++) begin
      for (int a = 0; a < 3; a++)
        do_alloc($urandom_range(0, 3), $urandom_range(1, 7), 1'($urandom_range(0, 1)),
                 mkline($urandom_range(0, 3), $urandom_range(0, 3),
                        $urandom_range(0, 3), $urandom_range(0, 3)), "R1 random alloc");
      for (int c = 0; c < 4; c++)
        do_commit($urandom_range(0, 3), $urandom_range(0, 7), NW'($urandom_range(0, 15)),
                  mkline($urandom_range(0, 3), $urandom_range(0, 3),
                         $urandom_range(0, 3), $urandom_range(0, 3)));
      do_resolve($urandom_range(1, 7), NW'($urandom_range(0, 15)), 1'b0, 0, "R3 R5 R6 random");
    end
    flush("R8 final flush");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule